// File: doc/BRIEF.md
# Two-Wire Slave Register-File Controller

This block is a synchronous two-wire (I2C) slave that gives a bus master access to a 160-byte register and RAM space. A system clock oversamples SCL and SDA, and SDA is driven open drain. The block detects START, repeated START and STOP. It matches a 7-bit device address and keeps one auto-incrementing byte pointer. A write transfer loads the pointer from its first byte and stores the bytes after it. A read transfer streams bytes starting at the pointer. The pointer can be set by a write, or a read can begin directly at wherever the pointer was left.

The low eight locations hold clock/calendar values owned by a time-keeping block. While a selected transfer has its pointer in that range, the block raises `freeze`. The time-keeping block then holds off copying fresh values into those registers, so a multi-byte read sees one coherent snapshot. A power-fail input aborts any transfer, clears the pointer and blinds the block to the bus until it falls. Analog glitch filtering and clock stretching are not included.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal 1101000 (bit 0 is R/W, 1 = read). Any other address gets no acknowledge, and the block then ignores the bus until the next START.
- R2: START is SDA falling while SCL is high, and it restarts address reception from any state. STOP is SDA rising while SCL is high, and it returns the block to idle.
- R3: After a matched address with R/W=0, the next byte is acknowledged and loaded into the pointer. A value of A0h or above loads 00h.
- R4: Every byte after the word address in a write transfer is acknowledged and stored at the pointer.
- R5: The pointer advances only on the acknowledge clock that follows a stored byte, or on a read byte that the master acknowledged. After 9Fh it wraps to 00h. A read byte that the master does not acknowledge leaves the pointer unchanged.
- R6: A read sends the byte at the pointer MSB first. A master acknowledge moves on to the next byte. A master non-acknowledge ends the transfer with SDA released.
- R7: A read that begins without a word address starts at the pointer left by the previous transfer.
- R8: `freeze` is high while a selected transfer has its pointer in 00h to 07h, and this holds across a repeated START. It falls after STOP, and when the pointer moves past 07h.
- R9: While `pwr_fail` is high, SDA is released, the pointer is 00h, nothing is stored and bus activity is ignored.
- R10: `sda_oe` = 1 pulls SDA low. It only rises while the sampled SCL is low.
- R11: After reset the pointer is 00h, all bytes read 00h, `sda_oe` is 0 and `freeze` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and blocks access |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| freeze | output | 1 | Hold off clock-register updates |

## Verification
A wrong pointer shows up within one byte as wrong read data, because every location holds a distinct value. A missing or extra increment on an acknowledge, or a broken wrap, shows on the very next current-address read. A wrong decode state shows up within the ninth clock of the affected byte, as a missing or spurious acknowledge. A wrong `freeze` flag shows right after the acknowledge clock that moves the pointer across the 07h/08h boundary, or after STOP.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } xfer_state_t;

    localparam int unsigned BYTE_BITS = 8;

    function automatic logic dev_match(input logic [7:0] rx, input logic [6:0] dev);
        return rx[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_rf_sampler.sv
module i2c_rf_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output i2c_rf_pkg::bus_ev_t  ev,
    output logic                 scl_lvl,
    output logic                 sda_lvl
);
    logic [STAGES-1:0] scl_sy, sda_sy;
    logic              scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sy <= '1;
            sda_sy <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[STAGES-2:0], scl_i};
            sda_sy <= {sda_sy[STAGES-2:0], sda_i};
            scl_d  <= scl_sy[STAGES-1];
            sda_d  <= sda_sy[STAGES-1];
        end
    end

    assign scl_lvl  = scl_sy[STAGES-1];
    assign sda_lvl  = sda_sy[STAGES-1];
    assign ev.rise  = scl_lvl & ~scl_d;
    assign ev.fall  = ~scl_lvl & scl_d;
    assign ev.start = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign ev.stop  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_rf_mem.sv
module i2c_rf_mem #(
    parameter int unsigned DEPTH = 160,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) cells[i] <= 8'h00;
        end else if (we && (32'(waddr) < DEPTH)) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = (32'(raddr) < DEPTH) ? cells[raddr] : 8'h00;

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h68,
    parameter int unsigned MEM_BYTES = 160,
    parameter int unsigned CLK_REGS  = 8,
    localparam int unsigned AW       = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          pwr_fail,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_oe,
    output logic          freeze
);
    xfer_state_t   state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg, txsh;
    logic          ack_drive, ack_phase, rw, selected, mst_ack;
    logic          byte_done, ptr_load;
    logic [AW-1:0] ptr_inc, ptr_ld_val;

    assign byte_done  = ev.fall && !ack_phase && (bitcnt == 4'd8);
    assign ptr_load   = byte_done && (state == ST_WADDR);
    assign wr_en      = byte_done && (state == ST_WDATA) && !pwr_fail;
    assign wr_data    = shreg;
    assign ptr_inc    = (32'(ptr) == MEM_BYTES - 1) ? '0 : ptr + 1'b1;
    assign ptr_ld_val = (32'(shreg) < MEM_BYTES) ? shreg[AW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '1;
            ack_drive <= 1'b0;
            ack_phase <= 1'b0;
            rw        <= 1'b0;
            selected  <= 1'b0;
            mst_ack   <= 1'b0;
            ptr       <= '0;
        end else if (ev.start) begin
            state     <= ST_DEV;
            bitcnt    <= '0;
            ack_drive <= 1'b0;
            ack_phase <= 1'b0;
        end else if (ev.stop) begin
            state     <= ST_IDLE;
            selected  <= 1'b0;
            ack_drive <= 1'b0;
            ack_phase <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (ev.rise) begin
                if (!ack_phase) begin
                    if (bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (state == ST_WDATA) begin
                    ptr <= ptr_inc;
                end else if (state == ST_RDATA) begin
                    mst_ack <= !sda_lvl;
                    if (!sda_lvl) ptr <= ptr_inc;
                end
            end
            if (ev.fall) begin
                if (byte_done) begin
                    unique case (state)
                        ST_DEV: begin
                            if (dev_match(shreg, DEV_ADDR)) begin
                                ack_drive <= 1'b1;
                                ack_phase <= 1'b1;
                                rw        <= shreg[0];
                                selected  <= 1'b1;
                            end else begin
                                state    <= ST_IDLE;
                                selected <= 1'b0;
                            end
                        end
                        ST_WADDR: begin
                            ptr       <= ptr_ld_val;
                            ack_drive <= 1'b1;
                            ack_phase <= 1'b1;
                        end
                        ST_WDATA: begin
                            ack_drive <= 1'b1;
                            ack_phase <= 1'b1;
                        end
                        default: begin
                            ack_phase <= 1'b1;
                        end
                    endcase
                end else if (!ack_phase && state == ST_RDATA && bitcnt != 4'd0) begin
                    txsh <= {txsh[6:0], 1'b1};
                end else if (ack_phase) begin
                    ack_drive <= 1'b0;
                    ack_phase <= 1'b0;
                    bitcnt    <= '0;
                    unique case (state)
                        ST_DEV: begin
                            state <= rw ? ST_RDATA : ST_WADDR;
                            if (rw) txsh <= rd_data;
                        end
                        ST_WADDR: state <= ST_WDATA;
                        ST_RDATA: begin
                            if (mst_ack) txsh <= rd_data;
                            else state <= ST_IDLE;
                        end
                        default: state <= state;
                    endcase
                end
            end
        end
    end

    assign sda_oe = ack_drive | ((state == ST_RDATA) && !ack_phase && !txsh[7]);
    assign freeze = selected && (32'(ptr) < CLK_REGS);

    // pointer never leaves the implemented space
    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (rst)
        32'(ptr) < MEM_BYTES);

    // pointer moves only by load, single step, or wrap/clear
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> (ptr == '0 || ptr == AW'($past(ptr) + 1'b1) || $past(ptr_load)));

    assert_pfail_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!sda_oe && ptr == '0 && !freeze));

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    assert_stop_unfreeze_R8: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !freeze);

    assert_no_ack_mismatch_R1: assert property (@(posedge clk) disable iff (rst)
        (byte_done && state == ST_DEV && !dev_match(shreg, DEV_ADDR) && !ev.start && !ev.stop)
            |=> !sda_oe);

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int unsigned MEM_BYTES   = 160,
    parameter int unsigned CLK_REGS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pwr_fail,
    output logic sda_oe,
    output logic freeze
);
    import i2c_rf_pkg::*;
    localparam int unsigned AW = $clog2(MEM_BYTES);

    bus_ev_t       ev;
    logic          scl_lvl, sda_lvl, wr_en;
    logic [AW-1:0] ptr;
    logic [7:0]    wr_data, rd_data;

    i2c_rf_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .ev(ev), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
    );

    i2c_rf_engine #(
        .DEV_ADDR(DEV_ADDR), .MEM_BYTES(MEM_BYTES), .CLK_REGS(CLK_REGS)
    ) u_engine (
        .clk(clk), .rst(rst), .ev(ev), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .pwr_fail(pwr_fail), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_oe(sda_oe), .freeze(freeze)
    );

    i2c_rf_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(ptr), .wdata(wr_data),
        .raddr(ptr), .rdata(rd_data)
    );

    assert_no_write_in_pfail_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> !wr_en);

endmodule

// File: tb/i2c_regfile_slave_bench.sv
module i2c_regfile_slave_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe, freeze, sda_line;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_mem [160];

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_regfile_slave u_i2c_regfile_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .pwr_fail(pwr_fail), .sda_oe(sda_oe), .freeze(freeze)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl = 1'b0;   tick(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl = 1'b1;   tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl = 1'b1;   tick(HALF);
            scl = 1'b0;
        end
        sda_m = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF / 2);
        acked = !sda_line;
        tick(HALF / 2);
        scl = 1'b0;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl = 1'b1; tick(HALF / 2);
            b[i] = sda_line;
            tick(HALF / 2);
            scl = 1'b0;
        end
        sda_m = !give_ack; tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        bit k;
        bus_start(); wr_byte(8'hD0, k); wr_byte(a, k); bus_stop();
    endtask

    task automatic cur_read1(input int expv, input string req);
        bit k;
        logic [7:0] d;
        bus_start(); wr_byte(8'hD1, k);
        chk(k, "R7 read address ack", int'(k), 1);
        rd_byte(1'b0, d);
        chk(d == 8'(expv), req, int'(d), expv);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit k;
        logic [7:0] d;
        for (int i = 0; i < 160; i++) exp_mem[i] = 8'h00;
        tick(5); rst = 1'b0; tick(5);

        // R11 reset state
        chk(sda_oe == 1'b0, "R11 sda_oe after reset", int'(sda_oe), 0);
        chk(freeze == 1'b0, "R11 freeze after reset", int'(freeze), 0);
        cur_read1(0, "R11 location 00h after reset");

        // R1 wrong device address, then ignored byte
        bus_start(); wr_byte(8'hA0, k);
        chk(!k, "R1 foreign address not acked", int'(k), 0);
        wr_byte(8'h00, k);
        chk(!k, "R1 bytes ignored until START", int'(k), 0);
        bus_stop();
        chk(freeze == 1'b0, "R1 not selected", int'(freeze), 0);

        // R3 R4 full-space write burst, pointer wraps to 00h
        bus_start(); wr_byte(8'hD0, k);
        chk(k, "R1 matching address acked", int'(k), 1);
        wr_byte(8'h00, k);
        chk(k, "R3 word address acked", int'(k), 1);
        for (int a = 0; a < 160; a++) begin
            wr_byte(pat(a), k);
            exp_mem[a] = pat(a);
            chk(k, "R4 data byte acked", int'(k), 1);
        end
        bus_stop();
        tick(4);
        chk(freeze == 1'b0, "R2 STOP returns to idle", int'(freeze), 0);

        // R7 R6 R5 current-address read across whole space
        bus_start(); wr_byte(8'hD1, k);
        chk(k, "R7 read address acked", int'(k), 1);
        for (int a = 0; a < 160; a++) begin
            rd_byte(a != 159, d);
            chk(d == exp_mem[a], "R6 R5 sequential read data", int'(d), int'(exp_mem[a]));
        end
        tick(2);
        chk(sda_oe == 1'b0, "R6 SDA released after NACK", int'(sda_oe), 0);
        bus_stop();
        cur_read1(int'(exp_mem[159]), "R5 NACK keeps pointer at 9Fh");

        // R8 freeze while pointer in clock range during writes
        bus_start(); wr_byte(8'hD0, k); wr_byte(8'h05, k); tick(4);
        chk(freeze, "R8 freeze with pointer 05h", int'(freeze), 1);
        wr_byte(8'h55, k); exp_mem[5] = 8'h55; tick(4);
        chk(freeze, "R8 freeze with pointer 06h", int'(freeze), 1);
        wr_byte(8'h66, k); exp_mem[6] = 8'h66; tick(4);
        chk(freeze, "R8 freeze with pointer 07h", int'(freeze), 1);
        wr_byte(8'h77, k); exp_mem[7] = 8'h77; tick(4);
        chk(!freeze, "R8 freeze drops past 07h", int'(freeze), 0);
        bus_stop();

        // R8 R2 repeated START keeps freeze; read 03h,04h
        bus_start(); wr_byte(8'hD0, k); wr_byte(8'h03, k);
        bus_start(); tick(2);
        chk(freeze, "R8 freeze across repeated START", int'(freeze), 1);
        wr_byte(8'hD1, k);
        chk(k, "R2 address acked after repeated START", int'(k), 1);
        rd_byte(1'b1, d);
        chk(d == exp_mem[3], "R6 read 03h", int'(d), int'(exp_mem[3]));
        rd_byte(1'b0, d);
        chk(d == exp_mem[4], "R6 read 04h", int'(d), int'(exp_mem[4]));
        chk(freeze, "R8 freeze until STOP", int'(freeze), 1);
        bus_stop(); tick(4);
        chk(!freeze, "R8 freeze cleared by STOP", int'(freeze), 0);

        // R5 wrap during read
        bus_start(); wr_byte(8'hD0, k); wr_byte(8'h9E, k);
        bus_start(); wr_byte(8'hD1, k);
        rd_byte(1'b1, d); chk(d == exp_mem[158], "R5 read 9Eh", int'(d), int'(exp_mem[158]));
        rd_byte(1'b1, d); chk(d == exp_mem[159], "R5 read 9Fh", int'(d), int'(exp_mem[159]));
        rd_byte(1'b0, d); chk(d == exp_mem[0], "R5 wrap to 00h", int'(d), int'(exp_mem[0]));
        bus_stop();
        cur_read1(int'(exp_mem[0]), "R5 pointer 00h after NACK");

        // R3 out-of-range word address loads 00h
        set_ptr(8'h40);
        set_ptr(8'hC5);
        cur_read1(int'(exp_mem[0]), "R3 word address C5h loads 00h");

        // R9 power fail aborts, clears pointer, blocks writes
        bus_start(); wr_byte(8'hD0, k); wr_byte(8'h02, k); tick(4);
        chk(freeze, "R8 freeze before power fail", int'(freeze), 1);
        pwr_fail = 1'b1; tick(2);
        chk(!freeze, "R9 freeze dropped on power fail", int'(freeze), 0);
        chk(!sda_oe, "R9 SDA released on power fail", int'(sda_oe), 0);
        wr_byte(8'h5A, k);
        chk(!k, "R9 no ack during power fail", int'(k), 0);
        bus_start(); wr_byte(8'hD0, k);
        chk(!k, "R9 START ignored during power fail", int'(k), 0);
        pwr_fail = 1'b0;
        bus_stop();
        cur_read1(int'(exp_mem[0]), "R9 pointer cleared to 00h");
        set_ptr(8'h02);
        cur_read1(int'(exp_mem[2]), "R9 location 02h not written");

        // R10 open-drain ack observed as a low line
        bus_start(); wr_byte(8'hD0, k);
        chk(k, "R10 ack pulls SDA low", int'(k), 1);
        bus_stop();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule